// File: doc/BRIEF.md
# Single-Bit Alias Window Bridge

This unit sits on the path between one 32-bit bus master and a memory or peripheral slave port. Two address windows, each 32 MB wide, act as bit aliases. Every 32-bit word in a window stands for one bit of a 1 MB backing region. An SRAM-side window at 0x22000000 backs the region at 0x20000000. A peripheral-side window at 0x42000000 backs the region at 0x40000000. Software can test or change a single bit with one load or one store, and needs no mask arithmetic.

An alias load becomes a slave read of the backing word. The selected bit comes back in bit 0 of the result. An alias store becomes an indivisible read-modify-write of the backing word, and the master sees it as one transfer. The master stays stalled until the slave has accepted the modified word, so no other access can slip in between the read and the write. Any access outside the alias windows is forwarded unchanged after one register stage. This includes accesses to the backing regions themselves.

Top module: `bitalias_bridge`

## Requirements
- R1: While reset is asserted, and after release until a request arrives, `m_ready` and `s_valid` are both low.
- R2: An access outside both alias windows is forwarded with one slave transfer. It appears at the slave one cycle after the master presents it, with address, direction, write data and byte strobes unchanged. The slave read data and error come back to the master unchanged. The backing regions are covered by this rule.
- R3: The alias windows are `A[31:25]==7'h11` and `A[31:25]==7'h21`. Their backing regions start at 0x20000000 and 0x40000000. Let `O = A[24:0]`. The backing word address is region base + `O[24:7]`×4, and the bit index is `O[6:2]`. The slave access for an alias load is a read of that word with all four strobes set.
- R4: An alias load returns the addressed bit in `m_rdata[0]` with bits 31:1 zero. A slave error is reported on `m_err`.
- R5: An alias store makes a slave read and then a slave write to the same word address, with all strobes set. The word written equals the word read, except that the addressed bit is replaced by `m_wdata[0]`. Bits 31:1 of `m_wdata` have no effect.
- R6: During an alias store, `m_ready` stays low until the cycle in which the slave accepts the write. Every request gets exactly one `m_ready` cycle.
- R7: An alias access with `A[1:0] != 2'b00` is answered with `m_err=1` and no slave transfer. The backing word is left unchanged.
- R8: If the slave answers the read of an alias store with an error, the master receives `m_err=1` and no slave write is issued.
- R9: The window edges decode exactly. Alias 0x23FFFFFC maps to bit 31 of 0x200FFFFC, and alias 0x43FFFFFC maps to bit 31 of 0x400FFFFC. Addresses 0x21FFFFFC, 0x24000000, 0x41FFFFF8 and 0x44000004 are forwarded as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_valid | input | 1 | Master request valid, held until `m_ready` |
| m_ready | output | 1 | Master transfer complete; response fields valid |
| m_write | input | 1 | Master request is a store |
| m_addr | input | 32 | Master byte address |
| m_wdata | input | 32 | Master store data |
| m_strb | input | 4 | Master byte strobes |
| m_rdata | output | 32 | Load result |
| m_err | output | 1 | Error response |
| s_valid | output | 1 | Slave request valid |
| s_ready | input | 1 | Slave transfer complete |
| s_write | output | 1 | Slave request is a write |
| s_addr | output | 32 | Slave byte address |
| s_wdata | output | 32 | Slave write data |
| s_strb | output | 4 | Slave byte strobes |
| s_rdata | input | 32 | Slave read data |
| s_err | input | 1 | Slave error response |

## Verification
The assertions assume a well-behaved master and slave. The master holds `m_valid` and its request fields steady until it sees `m_ready`. The slave raises `s_ready` for a single cycle, and only while `s_valid` is high. Under those conditions the bridge's slave request must stay stable while it waits, and every completion must be a one-cycle pulse. The bench master follows the same discipline. It only changes its request on a falling edge after the handshake edge. The bench slave answers after a programmable number of wait cycles, which exercises both the immediate case and the stalled case of the read-modify-write.

// File: rtl/bitalias_pkg.sv
package bitalias_pkg;

  // Controller phases.
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PASS,
    ST_ARD,
    ST_WRD,
    ST_WWR,
    ST_ERR
  } st_e;

  // Request classes produced by the decoder.
  typedef enum logic [1:0] {
    K_PASS,
    K_ARD,
    K_AWR,
    K_BAD
  } kind_e;

endpackage

// File: rtl/bitalias_decode.sv
module bitalias_decode
  import bitalias_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int NWIN      = 2,
  parameter int REGION_AW = 20,
  parameter logic [NWIN-1:0][AW-1:0] ALIAS_BASE  = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NWIN-1:0][AW-1:0] REGION_BASE = {32'h4000_0000, 32'h2000_0000},
  localparam int BIT_W    = $clog2(DW),
  localparam int LANE_W   = $clog2(DW / 8),
  localparam int ALIAS_AW = REGION_AW + BIT_W
) (
  input  logic [AW-1:0]    addr,
  input  logic             write,
  output kind_e            kind,
  output logic [AW-1:0]    word_addr,
  output logic [BIT_W-1:0] bit_idx
);

  logic [NWIN-1:0]    hit;
  logic [AW-1:0]      base_sel;
  logic               any_hit;
  logic [AW-1:0]      word_off;

  // One comparator per alias window.
  for (genvar w = 0; w < NWIN; w++) begin : g_win
    assign hit[w] = (addr[AW-1:ALIAS_AW] == ALIAS_BASE[w][AW-1:ALIAS_AW]);
  end

  always_comb begin
    base_sel = '0;
    any_hit  = 1'b0;
    for (int w = 0; w < NWIN; w++) begin
      if (hit[w]) begin
        base_sel = REGION_BASE[w];
        any_hit  = 1'b1;
      end
    end
  end

  // Every 2^(BIT_W+LANE_W) alias bytes cover one backing word.
  assign word_off  = AW'(addr[ALIAS_AW-1:BIT_W+LANE_W]) << LANE_W;
  assign word_addr = base_sel + word_off;
  assign bit_idx   = addr[BIT_W+LANE_W-1:LANE_W];

  always_comb begin
    if (!any_hit)                       kind = K_PASS;
    else if (addr[LANE_W-1:0] != '0)    kind = K_BAD;
    else if (write)                     kind = K_AWR;
    else                                kind = K_ARD;
  end

endmodule

// File: rtl/bitalias_ctrl.sv
module bitalias_ctrl
  import bitalias_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int BIT_W = $clog2(DW),
  localparam int SW    = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             m_valid,
  output logic             m_ready,
  input  logic             m_write,
  input  logic [AW-1:0]    m_addr,
  input  logic [DW-1:0]    m_wdata,
  input  logic [SW-1:0]    m_strb,
  output logic [DW-1:0]    m_rdata,
  output logic             m_err,
  input  kind_e            dec_kind,
  input  logic [AW-1:0]    dec_word_addr,
  input  logic [BIT_W-1:0] dec_bit,
  output logic             s_valid,
  input  logic             s_ready,
  output logic             s_write,
  output logic [AW-1:0]    s_addr,
  output logic [DW-1:0]    s_wdata,
  output logic [SW-1:0]    s_strb,
  input  logic [DW-1:0]    s_rdata,
  input  logic             s_err
);

  st_e              st_q, st_nxt;
  logic             ld_req, ld_merge;
  logic             req_write, req_val;
  logic [AW-1:0]    req_addr;
  logic [DW-1:0]    req_data;
  logic [SW-1:0]    req_strb;
  logic [BIT_W-1:0] req_bit;
  logic [DW-1:0]    merged;

  // Backing word with the addressed bit replaced.
  always_comb begin
    merged          = s_rdata;
    merged[req_bit] = req_val;
  end

  // Next-state and output decode.
  always_comb begin
    st_nxt   = st_q;
    ld_req   = 1'b0;
    ld_merge = 1'b0;
    m_ready  = 1'b0;
    m_err    = 1'b0;
    m_rdata  = s_rdata;
    s_valid  = 1'b0;
    s_write  = req_write;
    s_addr   = req_addr;
    s_wdata  = req_data;
    s_strb   = req_strb;
    unique case (st_q)
      ST_IDLE: begin
        if (m_valid) begin
          ld_req = 1'b1;
          unique case (dec_kind)
            K_PASS: st_nxt = ST_PASS;
            K_ARD:  st_nxt = ST_ARD;
            K_AWR:  st_nxt = ST_WRD;
            default: st_nxt = ST_ERR;
          endcase
        end
      end
      ST_PASS: begin
        s_valid = 1'b1;
        if (s_ready) begin
          m_ready = 1'b1;
          m_err   = s_err;
          st_nxt  = ST_IDLE;
        end
      end
      ST_ARD: begin
        s_valid = 1'b1;
        s_write = 1'b0;
        s_strb  = '1;
        if (s_ready) begin
          m_ready = 1'b1;
          m_err   = s_err;
          m_rdata = {{(DW-1){1'b0}}, s_rdata[req_bit]};
          st_nxt  = ST_IDLE;
        end
      end
      ST_WRD: begin
        s_valid = 1'b1;
        s_write = 1'b0;
        s_strb  = '1;
        if (s_ready) begin
          if (s_err) begin
            m_ready = 1'b1;
            m_err   = 1'b1;
            st_nxt  = ST_IDLE;
          end else begin
            ld_merge = 1'b1;
            st_nxt   = ST_WWR;
          end
        end
      end
      ST_WWR: begin
        s_valid = 1'b1;
        s_write = 1'b1;
        s_strb  = '1;
        if (s_ready) begin
          m_ready = 1'b1;
          m_err   = s_err;
          st_nxt  = ST_IDLE;
        end
      end
      default: begin
        m_ready = 1'b1;
        m_err   = 1'b1;
        m_rdata = '0;
        st_nxt  = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_write <= 1'b0;
      req_val   <= 1'b0;
      req_addr  <= '0;
      req_data  <= '0;
      req_strb  <= '0;
      req_bit   <= '0;
    end else if (ld_req) begin
      req_write <= m_write;
      req_val   <= m_wdata[0];
      req_addr  <= (dec_kind == K_PASS) ? m_addr : dec_word_addr;
      req_data  <= m_wdata;
      req_strb  <= m_strb;
      req_bit   <= dec_bit;
    end else if (ld_merge) begin
      req_data  <= merged;
    end
  end

  // Completion is always a single-cycle pulse.
  assert_single_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    m_ready |=> !m_ready);

  // A waiting slave request stays put.
  assert_req_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && !s_ready) |=> (s_valid && $stable(s_addr) && $stable(s_write)
                               && $stable(s_wdata) && $stable(s_strb)));

  // A good read phase is followed by a write to the same word.
  assert_rmw_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WRD && s_ready && !s_err) |=> (s_valid && s_write && $stable(s_addr)));

  // The written word differs from the word read in one bit at most.
  assert_rmw_one_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WRD && s_ready && !s_err) |=> ($countones(s_wdata ^ $past(s_rdata)) <= 1));

  // A completion without a slave answer can only be an error.
  assert_no_slave_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_ready && !s_ready) |-> (m_err && !s_valid));

  // Alias load results carry only bit 0.
  assert_alias_rdata_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_ready && !m_err && st_q == ST_ARD) |-> (m_rdata[DW-1:1] == '0));

endmodule

// File: rtl/bitalias_bridge.sv
module bitalias_bridge
  import bitalias_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int NWIN      = 2,
  parameter int REGION_AW = 20,
  parameter logic [NWIN-1:0][AW-1:0] ALIAS_BASE  = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NWIN-1:0][AW-1:0] REGION_BASE = {32'h4000_0000, 32'h2000_0000},
  localparam int BIT_W = $clog2(DW),
  localparam int SW    = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          m_valid,
  output logic          m_ready,
  input  logic          m_write,
  input  logic [AW-1:0] m_addr,
  input  logic [DW-1:0] m_wdata,
  input  logic [SW-1:0] m_strb,
  output logic [DW-1:0] m_rdata,
  output logic          m_err,
  output logic          s_valid,
  input  logic          s_ready,
  output logic          s_write,
  output logic [AW-1:0] s_addr,
  output logic [DW-1:0] s_wdata,
  output logic [SW-1:0] s_strb,
  input  logic [DW-1:0] s_rdata,
  input  logic          s_err
);

  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  kind_e            dec_kind;
  logic [AW-1:0]    dec_word_addr;
  logic [BIT_W-1:0] dec_bit;

  // Reset asserts at once and leaves on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  bitalias_decode #(
    .AW(AW), .DW(DW), .NWIN(NWIN), .REGION_AW(REGION_AW),
    .ALIAS_BASE(ALIAS_BASE), .REGION_BASE(REGION_BASE)
  ) i_decode (
    .addr      (m_addr),
    .write     (m_write),
    .kind      (dec_kind),
    .word_addr (dec_word_addr),
    .bit_idx   (dec_bit)
  );

  bitalias_ctrl #(.AW(AW), .DW(DW)) i_ctrl (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .m_valid       (m_valid),
    .m_ready       (m_ready),
    .m_write       (m_write),
    .m_addr        (m_addr),
    .m_wdata       (m_wdata),
    .m_strb        (m_strb),
    .m_rdata       (m_rdata),
    .m_err         (m_err),
    .dec_kind      (dec_kind),
    .dec_word_addr (dec_word_addr),
    .dec_bit       (dec_bit),
    .s_valid       (s_valid),
    .s_ready       (s_ready),
    .s_write       (s_write),
    .s_addr        (s_addr),
    .s_wdata       (s_wdata),
    .s_strb        (s_strb),
    .s_rdata       (s_rdata),
    .s_err         (s_err)
  );

  // Nothing is issued or completed while reset is held.
  assert_quiet_reset_R1: assert property (@(posedge clk)
    (!rst_sync_n) |-> (!m_ready && !s_valid));

endmodule

// File: tb/test_bitalias_bridge.sv
module test_bitalias_bridge;

  localparam logic [31:0] ERR_ADDR = 32'h200F_FF00;

  logic        clk, rst_n;
  logic        m_valid, m_ready, m_write, m_err;
  logic [31:0] m_addr, m_wdata, m_rdata;
  logic [3:0]  m_strb;
  logic        s_valid, s_ready, s_write, s_err;
  logic [31:0] s_addr, s_wdata, s_rdata;
  logic [3:0]  s_strb;

  int checks, fails;
  int wait_cycles;
  int xfer_cnt, wcnt;
  logic [31:0] mem [0:63];
  logic [31:0] last_addr, last_wdata;
  logic [3:0]  last_strb;
  logic        last_write, prev_write;
  logic        first_sv;
  logic [31:0] first_sa;

  bitalias_bridge i_bitalias_bridge (
    .clk(clk), .rst_n(rst_n),
    .m_valid(m_valid), .m_ready(m_ready), .m_write(m_write), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_strb(m_strb), .m_rdata(m_rdata), .m_err(m_err),
    .s_valid(s_valid), .s_ready(s_ready), .s_write(s_write), .s_addr(s_addr),
    .s_wdata(s_wdata), .s_strb(s_strb), .s_rdata(s_rdata), .s_err(s_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Slave model: word store indexed by address bits 7:2, programmable wait.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_ready <= 1'b0; s_err <= 1'b0; s_rdata <= '0;
      wcnt <= 0; xfer_cnt <= 0;
      last_addr <= '0; last_wdata <= '0; last_strb <= '0;
      last_write <= 1'b0; prev_write <= 1'b0;
    end else if (s_valid && !s_ready) begin
      if (wcnt >= wait_cycles) begin
        logic [31:0] w;
        logic        e;
        e = (s_addr == ERR_ADDR);
        w = mem[s_addr[7:2]];
        s_rdata <= w;
        s_err   <= e;
        s_ready <= 1'b1;
        wcnt    <= 0;
        xfer_cnt <= xfer_cnt + 1;
        prev_write <= last_write;
        last_addr <= s_addr; last_wdata <= s_wdata;
        last_strb <= s_strb; last_write <= s_write;
        if (s_write && !e) begin
          for (int k = 0; k < 4; k++)
            if (s_strb[k]) w[8*k +: 8] = s_wdata[8*k +: 8];
          mem[s_addr[7:2]] <= w;
        end
      end else begin
        wcnt <= wcnt + 1;
      end
    end else begin
      s_ready <= 1'b0;
      s_err   <= 1'b0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [31:0] a, input logic [31:0] wd,
                        input logic [3:0] st, output logic [31:0] rd,
                        output logic er, output int nx);
    int x0;
    @(negedge clk);
    x0 = xfer_cnt;
    m_valid = 1'b1; m_write = wr; m_addr = a; m_wdata = wd; m_strb = st;
    @(posedge clk);
    @(negedge clk);
    first_sv = s_valid;
    first_sa = s_addr;
    while (!m_ready) @(negedge clk);
    rd = m_rdata; er = m_err; nx = xfer_cnt - x0;
    @(posedge clk);
    @(negedge clk);
    m_valid = 1'b0;
  endtask

  function automatic logic [31:0] alias_of(input logic [31:0] abase,
                                           input logic [31:0] woff, input int n);
    return abase + (woff + 32'(n / 8)) * 32 + 32'(n % 8) * 4;
  endfunction

  initial begin
    logic [31:0] rd;
    logic        er;
    int          nx;
    logic [31:0] pass_list [0:6];
    logic [31:0] pat, shadow, wd;
    logic        b;
    checks = 0; fails = 0; wait_cycles = 0;
    m_valid = 0; m_write = 0; m_addr = 0; m_wdata = 0; m_strb = 0;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", {31'b0, m_ready}, 32'd0);
    chk("R1 s_valid in reset", {31'b0, s_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 ready after reset", {31'b0, m_ready}, 32'd0);
    chk("R1 s_valid after reset", {31'b0, s_valid}, 32'd0);

    // Forwarded accesses, including the window edges (R9).
    pass_list[0] = 32'h2000_0010; pass_list[1] = 32'h1000_0024;
    pass_list[2] = 32'h2400_0000; pass_list[3] = 32'h21FF_FFFC;
    pass_list[4] = 32'h41FF_FFF8; pass_list[5] = 32'h4400_0004;
    pass_list[6] = 32'h4000_0030;
    for (int i = 0; i < 7; i++) begin
      wd = pass_list[i] ^ (32'h1357_9BDF * 32'(i + 1));
      access(1'b1, pass_list[i], wd, 4'hF, rd, er, nx);
      chk("R2 one stage s_valid", {31'b0, first_sv}, 32'd1);
      chk("R2 R9 forwarded addr", first_sa, pass_list[i]);
      chk("R2 wdata", last_wdata, wd);
      chk("R2 write flag", {31'b0, last_write}, 32'd1);
      chk("R2 one transfer", 32'(nx), 32'd1);
      access(1'b0, pass_list[i], 32'h0, 4'hF, rd, er, nx);
      chk("R2 R9 read back", rd, wd);
      chk("R2 no err", {31'b0, er}, 32'd0);
      access(1'b1, pass_list[i], 32'hFFFF_FFFF, 4'(i + 3), rd, er, nx);
      chk("R2 strobes", {28'b0, last_strb}, {28'b0, 4'(i + 3)});
    end

    // Alias loads over every bit of an SRAM-side word.
    pat = 32'hA5C3_0F96;
    access(1'b1, 32'h2000_0000, pat, 4'hF, rd, er, nx);
    for (int n = 0; n < 32; n++) begin
      access(1'b0, alias_of(32'h2200_0000, 32'h0, n), 32'hFFFF_FFFF, 4'h0, rd, er, nx);
      chk("R4 alias bit", rd, {31'b0, pat[n]});
      chk("R3 word addr", last_addr, 32'h2000_0000);
      chk("R3 full strobes", {28'b0, last_strb}, 32'hF);
      chk("R3 read dir", {31'b0, last_write}, 32'd0);
    end

    // Alias loads on the peripheral side.
    pat = 32'h3C5A_96E1;
    access(1'b1, 32'h4000_0004, pat, 4'hF, rd, er, nx);
    for (int n = 0; n < 32; n++) begin
      access(1'b0, alias_of(32'h4200_0000, 32'h4, n), 32'h0, 4'hF, rd, er, nx);
      chk("R4 periph alias bit", rd, {31'b0, pat[n]});
      chk("R3 periph word addr", last_addr, 32'h4000_0004);
    end

    // Top of each window.
    access(1'b1, 32'h200F_FFFC, 32'h8000_0001, 4'hF, rd, er, nx);
    access(1'b0, 32'h23FF_FFFC, 32'h0, 4'hF, rd, er, nx);
    chk("R9 top alias bit31", rd, 32'd1);
    chk("R9 top word addr", last_addr, 32'h200F_FFFC);
    access(1'b0, 32'h23FF_FF80, 32'h0, 4'hF, rd, er, nx);
    chk("R9 top word bit0", rd, 32'd1);
    access(1'b0, 32'h23FF_FF84, 32'h0, 4'hF, rd, er, nx);
    chk("R9 top word bit1", rd, 32'd0);
    access(1'b0, 32'h43FF_FFFC, 32'h0, 4'hF, rd, er, nx);
    chk("R9 periph top word addr", last_addr, 32'h400F_FFFC);
    chk("R9 periph top bit31", rd, 32'd1);

    // Alias stores with a stalling slave.
    wait_cycles = 2;
    for (int pass = 0; pass < 2; pass++) begin
      shadow = (pass == 0) ? 32'h0 : 32'hFFFF_FFFF;
      access(1'b1, 32'h2000_0040, shadow, 4'hF, rd, er, nx);
      for (int n = 0; n < 32; n++) begin
        b = (pass == 0) ? ((n % 3) != 0) : ((n % 2) != 0);
        wd = {((n % 2) != 0) ? 31'h7FFF_FFFF : 31'h0, b};
        access(1'b1, alias_of(32'h2200_0000, 32'h40, n), wd, 4'h1, rd, er, nx);
        shadow[n] = b;
        chk("R6 done after read and write", 32'(nx), 32'd2);
        chk("R5 no err", {31'b0, er}, 32'd0);
        chk("R5 write last", {31'b0, last_write}, 32'd1);
        chk("R5 read first", {31'b0, prev_write}, 32'd0);
        chk("R5 write addr", last_addr, 32'h2000_0040);
        chk("R5 write strobes", {28'b0, last_strb}, 32'hF);
        chk("R5 merged word", last_wdata, shadow);
      end
      access(1'b0, 32'h2000_0040, 32'h0, 4'hF, rd, er, nx);
      chk("R5 stored word", rd, shadow);
    end

    // Misaligned alias accesses.
    wait_cycles = 0;
    access(1'b1, 32'h2200_0801, 32'h1, 4'hF, rd, er, nx);
    chk("R7 err on misaligned store", {31'b0, er}, 32'd1);
    chk("R7 no transfer", 32'(nx), 32'd0);
    access(1'b0, 32'h4200_0082, 32'h0, 4'hF, rd, er, nx);
    chk("R7 err on misaligned load", {31'b0, er}, 32'd1);
    chk("R7 no transfer load", 32'(nx), 32'd0);
    access(1'b0, 32'h2000_0040, 32'h0, 4'hF, rd, er, nx);
    chk("R7 word unchanged", rd, shadow);

    // Slave errors.
    access(1'b1, alias_of(32'h2200_0000, ERR_ADDR, 3), 32'h1, 4'hF, rd, er, nx);
    chk("R8 err on rmw read", {31'b0, er}, 32'd1);
    chk("R8 read only", 32'(nx), 32'd1);
    chk("R8 no write", {31'b0, last_write}, 32'd0);
    access(1'b0, alias_of(32'h2200_0000, ERR_ADDR, 4), 32'h0, 4'hF, rd, er, nx);
    chk("R4 load err", {31'b0, er}, 32'd1);
    access(1'b0, ERR_ADDR, 32'h0, 4'hF, rd, er, nx);
    chk("R2 err forwarded", {31'b0, er}, 32'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule